// File: doc/BRIEF.md
# Entropy Word Bank with Hardware Wipe

This block holds a bank of entropy words. An external SoC agent deposits them and an internal core consumes them. Both sides use one simple register port. A requester flag on that port tells the two apart. The SoC may read and write the words. The core may only read them, and it owns a one-bit wipe control.

A core write of 1 to the wipe bit raises a pulse that lasts exactly one cycle. The bit then falls on its own, with no further software action. While the pulse is high, every word in the bank is forced to zero through a hardware path. SoC writes to the words also need an external enable input to be high. Without it they do nothing.

Word offsets 0 to WORDS-1 select the entropy words. Offset WORDS selects the control register. Reads are combinational.

Top module: `entropy_word_bank`

## Requirements
- R1: While reset is held and right after it, every word reads 0 and the wipe bit (bit 0 at offset 12) reads 0.
- R2: A SoC write (reqIsSoc=1) to offset 0..11 with dataWrEnable=1 stores the write data. Either requester reads it back from the next cycle on.
- R3: A SoC write to a word with dataWrEnable=0 leaves the word unchanged.
- R4: A core write (reqIsSoc=0) to a word leaves the word unchanged.
- R5: A core write to offset 12 with bit 0 set makes bit 0 of offset 12 read 1 in the next cycle. It reads 0 in the cycle after that, with no further write.
- R6: A SoC write to offset 12 leaves the wipe bit at 0 and leaves all words unchanged.
- R7: In the cycle in which the wipe bit is 1, all twelve words are cleared. They read 0 from the next cycle on.
- R8: If a SoC data write lands in the same cycle as the wipe pulse, the wipe wins and the word ends at 0.
- R9: A read of an unmapped offset (13..15) returns 0. With the read strobe low, the read data is 0.
- R10: A core write of 0 to offset 12 raises no wipe pulse and leaves the words unchanged.
- R11: Reset is asynchronous and active low. Words clear as soon as rstN falls, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIsSoc | input | 1 | 1 = access from the SoC agent, 0 = access from the core |
| acsAddr | input | ADDR_W | Word offset of the access |
| acsWrData | input | DATA_W | Write data |
| acsWrEn | input | 1 | Write strobe |
| acsRdEn | input | 1 | Read strobe |
| dataWrEnable | input | 1 | Gates SoC writes to the entropy words |
| acsRdData | output | DATA_W | Combinational read data |

## Verification
The bench builds the block with its defaults: 12 words of 32 bits and a 4-bit offset. With these values, the three offsets above the control register (13 to 15) can be addressed, so unmapped reads are exercised. Every word is filled with a distinct value, so one missed wipe or one stray write shows up in a readback. The wipe pulse is also made to collide with a SoC write, and a reset is dropped between clock edges.

// File: rtl/entropy_bank_pkg.sv
package entropy_bank_pkg;

  // Strobes passed from the access decoder to the storage datapath.
  typedef struct packed {
    logic wordWrite;  // accepted SoC write to the addressed word
    logic clearAll;   // wipe pulse, zeroes every word
    logic readWord;   // read of an in-range word offset
    logic readCtrl;   // read of the control offset
  } bankStrobe_t;

endpackage

// File: rtl/entropy_bank_ctrl.sv
module entropy_bank_ctrl
  import entropy_bank_pkg::*;
#(
  parameter int WORDS  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqIsSoc,
  input  logic [ADDR_W-1:0] acsAddr,
  input  logic              wrBit0,
  input  logic              acsWrEn,
  input  logic              acsRdEn,
  input  logic              dataWrEnable,
  output bankStrobe_t       strobe,
  output logic              clrBit
);

  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(WORDS);

  logic inRange;
  logic isCtrl;
  logic clrSet;

  assign inRange = (acsAddr < CtrlAddr);
  assign isCtrl  = (acsAddr == CtrlAddr);

  // Only the core may raise the wipe; each write lasts one cycle.
  assign clrSet = acsWrEn && !reqIsSoc && isCtrl && wrBit0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clrBit <= 1'b0;
    else       clrBit <= clrSet;
  end

  always_comb begin
    strobe.wordWrite = acsWrEn && reqIsSoc && dataWrEnable && inRange;
    strobe.clearAll  = clrBit;
    strobe.readWord  = acsRdEn && inRange;
    strobe.readCtrl  = acsRdEn && isCtrl;
  end

endmodule

// File: rtl/entropy_bank_data.sv
module entropy_bank_data
  import entropy_bank_pkg::*;
#(
  parameter int WORDS  = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bankStrobe_t             strobe,
  input  logic [ADDR_W-1:0]       acsAddr,
  input  logic [DATA_W-1:0]       acsWrData,
  output logic [WORDS*DATA_W-1:0] wordsFlat,
  output logic [DATA_W-1:0]       acsRdData
);

  logic [DATA_W-1:0] wordQ [WORDS];

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic hit;
    assign hit = strobe.wordWrite && (acsAddr == ADDR_W'(gi));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                wordQ[gi] <= '0;
      else if (strobe.clearAll) wordQ[gi] <= '0;   // wipe beats a write
      else if (hit)             wordQ[gi] <= acsWrData;
    end

    assign wordsFlat[gi*DATA_W +: DATA_W] = wordQ[gi];
  end

  always_comb begin
    acsRdData = '0;
    if (strobe.readWord) begin
      for (int i = 0; i < WORDS; i++) begin
        if (acsAddr == ADDR_W'(i)) acsRdData = wordQ[i];
      end
    end else if (strobe.readCtrl) begin
      acsRdData = DATA_W'(strobe.clearAll);
    end
  end

endmodule

// File: rtl/entropy_word_bank.sv
module entropy_word_bank
  import entropy_bank_pkg::*;
#(
  parameter int WORDS  = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqIsSoc,
  input  logic [ADDR_W-1:0] acsAddr,
  input  logic [DATA_W-1:0] acsWrData,
  input  logic              acsWrEn,
  input  logic              acsRdEn,
  input  logic              dataWrEnable,
  output logic [DATA_W-1:0] acsRdData
);

  bankStrobe_t             strobe;
  logic                    clrBit;
  logic [WORDS*DATA_W-1:0] wordsFlat;

  entropy_bank_ctrl #(.WORDS(WORDS), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqIsSoc(reqIsSoc), .acsAddr(acsAddr),
    .wrBit0(acsWrData[0]), .acsWrEn(acsWrEn), .acsRdEn(acsRdEn),
    .dataWrEnable(dataWrEnable), .strobe(strobe), .clrBit(clrBit)
  );

  entropy_bank_data #(.WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .acsAddr(acsAddr),
    .acsWrData(acsWrData), .wordsFlat(wordsFlat), .acsRdData(acsRdData)
  );

endmodule

// File: rtl/entropy_word_bank_chk.sv
module entropy_word_bank_chk #(
  parameter int WORDS  = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqIsSoc,
  input logic [ADDR_W-1:0]       acsAddr,
  input logic [DATA_W-1:0]       acsWrData,
  input logic                    acsWrEn,
  input logic                    acsRdEn,
  input logic                    dataWrEnable,
  input logic [DATA_W-1:0]       acsRdData,
  input logic                    clrBit,
  input logic [WORDS*DATA_W-1:0] wordsFlat
);

  logic coreSetsClr;
  assign coreSetsClr = acsWrEn && !reqIsSoc && (acsAddr == ADDR_W'(WORDS)) && acsWrData[0];

  // R5: the wipe bit falls by itself unless re-armed
  p_pulse_falls_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrBit && !coreSetsClr) |=> !clrBit);

  // R6 / R10: only a core write of 1 raises the wipe
  p_only_core_arms_r6: assert property (@(posedge clk) disable iff (!rstN)
    !coreSetsClr |=> !clrBit);

  // R7 / R8: after a wipe cycle every word is zero
  p_wipe_zeroes_r7: assert property (@(posedge clk) disable iff (!rstN)
    clrBit |=> (wordsFlat == '0));

  // R3 / R4: words hold without an enabled SoC write or a wipe
  p_words_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!(acsWrEn && reqIsSoc && dataWrEnable) && !clrBit) |=> $stable(wordsFlat));

  // R9: unmapped offsets and idle reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!acsRdEn || acsAddr > ADDR_W'(WORDS)) |-> (acsRdData == '0));

endmodule

bind entropy_word_bank entropy_word_bank_chk #(
  .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rstN(rstN), .reqIsSoc(reqIsSoc), .acsAddr(acsAddr),
  .acsWrData(acsWrData), .acsWrEn(acsWrEn), .acsRdEn(acsRdEn),
  .dataWrEnable(dataWrEnable), .acsRdData(acsRdData), .clrBit(clrBit),
  .wordsFlat(wordsFlat)
);

// File: tb/test_entropy_word_bank.sv
module test_entropy_word_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqIsSoc = 1'b0;
  logic [3:0]  acsAddr = '0;
  logic [31:0] acsWrData = '0;
  logic        acsWrEn = 1'b0;
  logic        acsRdEn = 1'b0;
  logic        dataWrEnable = 1'b0;
  logic [31:0] acsRdData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model
  logic [31:0] model [NW];
  bit          modelClr;

  entropy_word_bank i_entropy_word_bank (
    .clk(clk), .rstN(rstN), .reqIsSoc(reqIsSoc), .acsAddr(acsAddr),
    .acsWrData(acsWrData), .acsWrEn(acsWrEn), .acsRdEn(acsRdEn),
    .dataWrEnable(dataWrEnable), .acsRdData(acsRdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expRead();
    if (!acsRdEn)          return 32'h0;
    if (acsAddr < 4'd12)   return model[acsAddr];
    if (acsAddr == 4'd12)  return {31'h0, modelClr};
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: read data %h, expected %h (addr %0d)", tag, act, exp, acsAddr);
    end
  endtask

  // One clock of stimulus: drive after the falling edge, check, then advance model.
  task automatic cyc(input bit soc, input bit wr, input bit rd, input bit wen,
                     input int addr, input logic [31:0] data, input string tag);
    @(negedge clk);
    reqIsSoc = soc; acsWrEn = wr; acsRdEn = rd; dataWrEnable = wen;
    acsAddr = 4'(addr); acsWrData = data;
    #1;
    check(tag, acsRdData, expRead());
    @(posedge clk);
    if (modelClr) begin
      for (int i = 0; i < NW; i++) model[i] = 32'h0;
    end else if (wr && soc && wen && addr < NW) begin
      model[addr] = data;
    end
    modelClr = wr && !soc && addr == NW && data[0];
  endtask

  task automatic rd(input bit soc, input int addr, input string tag);
    cyc(soc, 1'b0, 1'b1, 1'b0, addr, 32'h0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual running, expected done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) model[i] = 32'h0;
    modelClr = 0;
    // R1: reads during and after reset
    #(CLK_PERIOD * 2 + 1);
    acsRdEn = 1; acsAddr = 4'd0; #1;
    check("R1", acsRdData, 32'h0);
    acsAddr = 4'd12; #1;
    check("R1", acsRdData, 32'h0);
    acsRdEn = 0;
    @(negedge clk); rstN = 1;
    rd(0, 0, "R1");
    rd(1, 12, "R1");

    // R2: fill all words from the SoC, read back from both sides
    for (int i = 0; i < NW; i++) cyc(1, 1, 0, 1, i, 32'hA500_0000 + i * 32'h1111, "R2");
    for (int i = 0; i < NW; i++) rd(0, i, "R2");
    rd(1, 7, "R2");

    // R3: SoC write with enable low
    cyc(1, 1, 0, 0, 3, 32'hDEAD_0003, "R3");
    rd(0, 3, "R3");
    // R4: core write to a word
    cyc(0, 1, 0, 1, 4, 32'hBEEF_0004, "R4");
    rd(1, 4, "R4");
    // R6: SoC write to the control offset
    cyc(1, 1, 0, 1, 12, 32'hFFFF_FFFF, "R6");
    rd(0, 12, "R6");
    rd(0, 0, "R6");
    // R10: core write of 0 to control
    cyc(0, 1, 0, 1, 12, 32'hFFFF_FFFE, "R10");
    rd(0, 12, "R10");
    rd(1, 5, "R10");

    // R5 / R7: wipe pulse, self-clear, all words zero
    cyc(0, 1, 0, 0, 12, 32'h1, "R5");
    rd(0, 12, "R5");
    rd(0, 12, "R5");
    for (int i = 0; i < NW; i++) rd(1, i, "R7");

    // R8: wipe collides with an enabled SoC write
    cyc(1, 1, 0, 1, 2, 32'h1234_5678, "R8");
    cyc(1, 1, 0, 1, 9, 32'h0BAD_0009, "R8");
    cyc(0, 1, 0, 0, 12, 32'h1, "R8");
    cyc(1, 1, 1, 1, 2, 32'h7777_7777, "R8");
    rd(0, 2, "R8");
    rd(0, 9, "R8");

    // R9: unmapped offsets and idle read strobe
    cyc(1, 1, 0, 1, 6, 32'h6666_6666, "R9");
    rd(0, 13, "R9");
    rd(1, 15, "R9");
    cyc(0, 0, 0, 0, 6, 32'h0, "R9");

    // R11: asynchronous reset between clock edges
    cyc(1, 1, 0, 1, 5, 32'h5555_5555, "R11");
    rd(0, 5, "R11");
    @(negedge clk);
    acsWrEn = 0; acsRdEn = 1; acsAddr = 4'd5;
    #1 rstN = 0;
    #1;
    for (int i = 0; i < NW; i++) model[i] = 32'h0;
    modelClr = 0;
    check("R11", acsRdData, 32'h0);
    @(negedge clk); rstN = 1;
    rd(1, 5, "R11");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule